// File: doc/BRIEF.md
# Indexed System Information Port

This block gives software read access to a table of 32-bit battery and system information words through two registers: an index register that selects a word and a data register that returns it. A host-side controller fills the table through a separate parallel load port (write enable, address, data). Software first writes a word number to the index register and then reads the data register. A read of a word number the block does not know returns all ones and raises a one-cycle protocol-error pulse.

Some software writes byte offsets to the index register instead of word numbers. To cope with this, the block starts in a scaling mode that divides every written index by four. Software leaves that mode with a handshake: it selects the handshake word and then writes the data register. One word of the table reports whether a selected CPU is locked. The CPU is chosen by an earlier data write to that same word. The word after the last table entry is an end marker. It reads as zero and raises no error.

All bus accesses take one cycle. Read responses come back registered, one cycle after the access.

Top module: `sysinfo_port`

## Requirements
- R1: After reset the latched index is 0 and scaling mode is active.
- R2: Only word-size accesses (`acc_size` = 2; 0 is byte, 1 is halfword) take effect. A read of another size returns `rsp_unused` = 1 with data 0 and no error. A write of another size changes nothing and raises `proto_err`.
- R3: A word write of 0x80 to the index register (`acc_sel` = 0) leaves the latched index unchanged and raises no error.
- R4: While scaling mode is active, any other value written to the index register is shifted right by 2 before it is latched. A read of the index register returns the latched index.
- R5: A word data write (`acc_sel` = 1) while the index equals 0x200 clears scaling mode without error. From then on, index writes are latched unshifted.
- R6: A data read with index 0 to 25, other than 11, returns the table word most recently loaded at that address through the load port, without error.
- R7: A data read with an index above 26, or any other unlisted index such as 0x200, returns 0xFFFFFFFF and raises `proto_err`.
- R8: A word data write while the index equals 11 selects a CPU. The selection is valid when the written value is below `NUM_CPUS`. A data read at index 11 with a valid selection returns that CPU's `cpu_locked` bit in bit 0, with zeros above, and no error.
- R9: A data read at index 11 with no valid selection, whether none has been made since reset or the last one was out of range, returns 1 and raises `proto_err`.
- R10: A data read at index 26 returns 0 and raises no error.
- R11: A word data write at any index other than 11 and 0x200 changes nothing and raises `proto_err`.
- R12: `rsp_valid` is high for exactly the cycle after each read access, and `rsp_data`, `rsp_unused` and `proto_err` are valid in that same cycle. Writes never assert `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = index register, 1 = data register |
| acc_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| acc_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response strobe |
| rsp_data | output | 32 | Read data |
| rsp_unused | output | 1 | Read had an unsupported size |
| proto_err | output | 1 | One-cycle protocol-error pulse |
| tbl_we | input | 1 | Host table load enable |
| tbl_addr | input | 5 | Host table load address |
| tbl_wdata | input | 32 | Host table load data |
| cpu_locked | input | NUM_CPUS | Per-CPU locked flags |

## Verification
On every cycle, the assertions check the following:
- A 0x80 index write holds the index, and any other index write is latched with the right scaling.
- The handshake clears scaling mode.
- A CPU selection is valid only for an in-range value.
- Unused responses carry zero data.
- A response strobe appears only after a read.

The values that come back from the table, the all-ones and error results for unknown indices, the lock-flag path and the end marker can only be shown by the bench's directed scenarios, because they depend on what was loaded and on the order of the index and data accesses.

// File: rtl/sysinfo_pkg.sv
package sysinfo_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // index values with special behaviour
    localparam logic [WORD_W-1:0] IDX_KEEP      = 32'h0000_0080;
    localparam logic [WORD_W-1:0] IDX_HANDSHAKE = 32'h0000_0200;
    localparam logic [WORD_W-1:0] IDX_CPU_LOCK  = 32'd11;
    localparam logic [WORD_W-1:0] IDX_END       = 32'd26;
    localparam int               TABLE_DEPTH   = 26;
    localparam int               TABLE_AW      = $clog2(TABLE_DEPTH);

    typedef struct packed {
        logic              valid;
        logic              unused;
        logic              err;
        logic [WORD_W-1:0] data;
    } rsp_t;

    function automatic logic is_word(input logic [1:0] sz);
        return acc_size_e'(sz) == SZ_WORD;
    endfunction

    function automatic logic is_table_idx(input logic [WORD_W-1:0] idx);
        return (idx < WORD_W'(TABLE_DEPTH)) && (idx != IDX_CPU_LOCK);
    endfunction

endpackage

// File: rtl/sysinfo_index_reg.sv
module sysinfo_index_reg
    import sysinfo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              clr_scale,
    output logic [WORD_W-1:0] index,
    output logic              scale_on
);

    logic [WORD_W-1:0] index_n;

    always_comb begin
        index_n = index;
        if (wr_en && (wdata != IDX_KEEP)) begin
            index_n = scale_on ? (wdata >> 2) : wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            index    <= '0;
            scale_on <= 1'b1;
        end else begin
            index <= index_n;
            if (clr_scale) begin
                scale_on <= 1'b0;
            end
        end
    end

    // R3: the keep value leaves the index alone
    a_r3_keep_index: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata == IDX_KEEP) |=> index == $past(index));

    // R4: scaled latch while scaling mode is on
    a_r4_scaled_latch: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata != IDX_KEEP && scale_on) |=> index == ($past(wdata) >> 2));

    // R5: handshake clears scaling mode
    a_r5_scale_cleared: assert property (@(posedge clk) disable iff (rst)
        clr_scale |=> !scale_on);

    // R5: scaling mode never returns without reset
    a_r5_scale_sticky: assert property (@(posedge clk) disable iff (rst)
        !scale_on |=> !scale_on);

endmodule

// File: rtl/sysinfo_table.sv
module sysinfo_table
    import sysinfo_pkg::*;
#(
    parameter int DEPTH = TABLE_DEPTH,
    parameter int AW    = TABLE_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [AW-1:0]     ld_addr,
    input  logic [WORD_W-1:0] ld_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] entry [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry[g] <= '0;
            end else if (ld_en && ld_addr == AW'(g)) begin
                entry[g] <= ld_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_addr == AW'(i)) begin
                rd_data = entry[i];
            end
        end
    end

endmodule

// File: rtl/sysinfo_cpu_sel.sv
module sysinfo_cpu_sel
    import sysinfo_pkg::*;
#(
    parameter int NUM_CPUS = 4,
    localparam int SEL_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [NUM_CPUS-1:0] cpu_locked,
    output logic                lock_bit,
    output logic                sel_valid
);

    logic [SEL_W-1:0] sel;
    logic             in_range;

    assign in_range = wdata < WORD_W'(NUM_CPUS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel       <= '0;
            sel_valid <= 1'b0;
        end else if (wr_en) begin
            sel       <= in_range ? wdata[SEL_W-1:0] : '0;
            sel_valid <= in_range;
        end
    end

    assign lock_bit = cpu_locked[sel];

    // R8: a valid selection always names an existing CPU
    a_r8_sel_in_range: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (WORD_W'(sel) < WORD_W'(NUM_CPUS)));

    // R9: an out-of-range write leaves no valid selection
    a_r9_bad_sel_invalid: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wdata >= WORD_W'(NUM_CPUS)) |=> !sel_valid);

endmodule

// File: rtl/sysinfo_port.sv
module sysinfo_port
    import sysinfo_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  logic                acc_sel,
    input  logic [1:0]          acc_size,
    input  logic [31:0]         acc_wdata,
    output logic                rsp_valid,
    output logic [31:0]         rsp_data,
    output logic                rsp_unused,
    output logic                proto_err,
    input  logic                tbl_we,
    input  logic [4:0]          tbl_addr,
    input  logic [31:0]         tbl_wdata,
    input  logic [NUM_CPUS-1:0] cpu_locked
);

    logic              word_ok;
    logic              idx_wr;
    logic              data_wr;
    logic              clr_scale;
    logic              cpu_wr;
    logic              wr_err;
    logic [WORD_W-1:0] index;
    logic              scale_on;
    logic [WORD_W-1:0] tbl_rd;
    logic              lock_bit;
    logic              sel_valid;
    rsp_t              rsp_n;
    rsp_t              rsp_q;

    assign word_ok   = is_word(acc_size);
    assign idx_wr    = acc_valid && acc_write && !acc_sel && word_ok;
    assign data_wr   = acc_valid && acc_write && acc_sel && word_ok;
    assign clr_scale = data_wr && (index == IDX_HANDSHAKE);
    assign cpu_wr    = data_wr && (index == IDX_CPU_LOCK);
    assign wr_err    = acc_valid && acc_write &&
                       (!word_ok || (acc_sel && !clr_scale && !cpu_wr));

    sysinfo_index_reg u_index (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (idx_wr),
        .wdata     (acc_wdata),
        .clr_scale (clr_scale),
        .index     (index),
        .scale_on  (scale_on)
    );

    sysinfo_table #(
        .DEPTH (TABLE_DEPTH),
        .AW    (TABLE_AW)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (tbl_we),
        .ld_addr (tbl_addr),
        .ld_data (tbl_wdata),
        .rd_addr (index[TABLE_AW-1:0]),
        .rd_data (tbl_rd)
    );

    sysinfo_cpu_sel #(
        .NUM_CPUS (NUM_CPUS)
    ) u_cpu (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (cpu_wr),
        .wdata      (acc_wdata),
        .cpu_locked (cpu_locked),
        .lock_bit   (lock_bit),
        .sel_valid  (sel_valid)
    );

    always_comb begin
        rsp_n = '{valid: 1'b0, unused: 1'b0, err: wr_err, data: '0};
        if (acc_valid && !acc_write) begin
            rsp_n.valid = 1'b1;
            if (!word_ok) begin
                rsp_n.unused = 1'b1;
            end else if (!acc_sel) begin
                rsp_n.data = index;
            end else if (is_table_idx(index)) begin
                rsp_n.data = tbl_rd;
            end else if (index == IDX_CPU_LOCK) begin
                rsp_n.data = sel_valid ? {{(WORD_W-1){1'b0}}, lock_bit} : 32'd1;
                rsp_n.err  = !sel_valid;
            end else if (index == IDX_END) begin
                rsp_n.data = '0;
            end else begin
                rsp_n.data = '1;
                rsp_n.err  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_n;
        end
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_data   = rsp_q.data;
    assign rsp_unused = rsp_q.unused;
    assign proto_err  = rsp_q.err;

    // R12: a strobe only follows a read access
    a_r12_strobe_after_read: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_write) |=> rsp_valid);

    a_r12_no_strobe_after_write: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && !acc_write) |=> !rsp_valid);

    // R2: unused responses carry zero data and no error
    a_r2_unused_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_unused |-> (rsp_valid && rsp_data == '0 && !proto_err));

    // R2: a short write never moves the index
    a_r2_short_write_keeps: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && !word_ok) |=> index == $past(index));

endmodule

// File: tb/test_sysinfo_port.sv
module test_sysinfo_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_sel = 1'b0;
    logic [1:0]  acc_size = 2'd2;
    logic [31:0] acc_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        rsp_unused;
    logic        proto_err;
    logic        tbl_we = 1'b0;
    logic [4:0]  tbl_addr = '0;
    logic [31:0] tbl_wdata = '0;
    logic [3:0]  cpu_locked = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic        r_valid, r_unused, r_err;
    logic [31:0] r_data;
    logic [31:0] model_tbl [26];

    always #2 clk = ~clk;

    sysinfo_port #(.NUM_CPUS(4)) i_sysinfo_port (
        .clk (clk), .rst (rst),
        .acc_valid (acc_valid), .acc_write (acc_write), .acc_sel (acc_sel),
        .acc_size (acc_size), .acc_wdata (acc_wdata),
        .rsp_valid (rsp_valid), .rsp_data (rsp_data), .rsp_unused (rsp_unused),
        .proto_err (proto_err),
        .tbl_we (tbl_we), .tbl_addr (tbl_addr), .tbl_wdata (tbl_wdata),
        .cpu_locked (cpu_locked)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // one access; response captured at the next falling edge
    task automatic access(input logic wr, input logic sel, input logic [1:0] sz,
                          input logic [31:0] wd);
        acc_valid = 1'b1; acc_write = wr; acc_sel = sel; acc_size = sz; acc_wdata = wd;
        @(negedge clk);
        r_valid = rsp_valid; r_data = rsp_data; r_unused = rsp_unused; r_err = proto_err;
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic load(input int a, input logic [31:0] v);
        tbl_we = 1'b1; tbl_addr = 5'(a); tbl_wdata = v;
        @(negedge clk);
        tbl_we = 1'b0;
        if (a < 26) model_tbl[a] = v;
    endtask

    task automatic read_index(input string req, input logic [31:0] exp);
        access(1'b0, 1'b0, 2'd2, '0);
        chk(req, r_data, exp);
    endtask

    task automatic t_reset;
        read_index("R1 index after reset", 32'd0);
        access(1'b1, 1'b0, 2'd2, 32'd8);
        read_index("R1 scaling active after reset", 32'd2);
    endtask

    task automatic t_scale_keep;
        access(1'b1, 1'b0, 2'd2, 32'h64);
        read_index("R4 scaled index", 32'h19);
        access(1'b1, 1'b0, 2'd2, 32'h80);
        chk("R3 keep write no error", {31'b0, r_err}, 32'd0);
        read_index("R3 index kept", 32'h19);
    endtask

    task automatic t_table;
        for (int i = 0; i < 26; i++) load(i, 32'hA500_0000 ^ (32'(i) * 32'h0101_0101));
        for (int k = 0; k < 3; k++) begin
            automatic int ix = (k == 0) ? 0 : (k == 1) ? 5 : 25;
            access(1'b1, 1'b0, 2'd2, 32'(ix * 4));
            access(1'b0, 1'b1, 2'd2, '0);
            chk("R6 table word", r_data, model_tbl[ix]);
            chk("R6 no error", {31'b0, r_err}, 32'd0);
            chk("R12 strobe after read", {31'b0, r_valid}, 32'd1);
        end
        load(5, 32'h1234_5678);
        access(1'b1, 1'b0, 2'd2, 32'd20);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R6 reload", r_data, 32'h1234_5678);
    endtask

    task automatic t_unknown;
        access(1'b1, 1'b0, 2'd2, 32'd108);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R7 unknown data", r_data, 32'hFFFF_FFFF);
        chk("R7 unknown err", {31'b0, r_err}, 32'd1);
    endtask

    task automatic t_end;
        access(1'b1, 1'b0, 2'd2, 32'd104);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R10 end data", r_data, 32'd0);
        chk("R10 end no err", {31'b0, r_err}, 32'd0);
    endtask

    task automatic t_cpu;
        access(1'b1, 1'b0, 2'd2, 32'd44);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R9 no selection data", r_data, 32'd1);
        chk("R9 no selection err", {31'b0, r_err}, 32'd1);
        access(1'b1, 1'b1, 2'd2, 32'd9);
        chk("R9 bad select write no err", {31'b0, r_err}, 32'd0);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R9 bad select err", {31'b0, r_err}, 32'd1);
        access(1'b1, 1'b1, 2'd2, 32'd2);
        cpu_locked = 4'b0100;
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R8 locked cpu", r_data, 32'd1);
        chk("R8 no err", {31'b0, r_err}, 32'd0);
        cpu_locked = 4'b1011;
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R8 unlocked cpu", r_data, 32'd0);
    endtask

    task automatic t_width;
        access(1'b1, 1'b0, 2'd2, 32'd12);
        access(1'b0, 1'b1, 2'd1, '0);
        chk("R2 short read unused", {31'b0, r_unused}, 32'd1);
        chk("R2 short read data", r_data, 32'd0);
        chk("R2 short read no err", {31'b0, r_err}, 32'd0);
        access(1'b1, 1'b0, 2'd0, 32'd7);
        chk("R2 short write err", {31'b0, r_err}, 32'd1);
        chk("R12 no strobe on write", {31'b0, r_valid}, 32'd0);
        read_index("R2 short write ignored", 32'd3);
    endtask

    task automatic t_bad_write;
        access(1'b1, 1'b1, 2'd2, 32'hDEAD_BEEF);
        chk("R11 stray data write err", {31'b0, r_err}, 32'd1);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R11 table unchanged", r_data, model_tbl[3]);
        read_index("R11 index unchanged", 32'd3);
    endtask

    task automatic t_handshake;
        access(1'b1, 1'b0, 2'd2, 32'h800);
        read_index("R5 handshake index", 32'h200);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R7 handshake index read ones", r_data, 32'hFFFF_FFFF);
        access(1'b1, 1'b1, 2'd2, 32'd0);
        chk("R5 handshake no err", {31'b0, r_err}, 32'd0);
        access(1'b1, 1'b0, 2'd2, 32'd5);
        read_index("R5 unscaled index", 32'd5);
        access(1'b0, 1'b1, 2'd2, '0);
        chk("R5 unscaled table read", r_data, model_tbl[5]);
        access(1'b1, 1'b0, 2'd2, 32'h80);
        read_index("R3 keep unscaled", 32'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R12 idle after reset", {31'b0, rsp_valid}, 32'd0);
        t_reset();
        t_scale_keep();
        t_table();
        t_unknown();
        t_end();
        t_cpu();
        t_width();
        t_bad_write();
        t_handshake();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule